// File: doc/BRIEF.md
# I2C Controller Register Bank with Set/Clear Aliases

This block is the software-visible register file of a small I2C master. It holds two 32-bit control words. Each control word can be reached at three word addresses: a plain store, a bit-set alias that ORs the written ones into the word, and a bit-clear alias that removes the written ones from it. Software can therefore change one field without a read-modify-write sequence. A read-only status word reports the state of the bus engine.

The second control word carries eight interrupt flags in its low byte and their enables in the byte just above. A command engine raises flags through a pulse input. Software clears the flags through the clear alias. A level interrupt output is high while any enabled flag is set. The first control word drives the engine. Its top bit is a self-clearing soft reset, and bit 29 is a run bit that the engine drops when a command ends. Bit 28 of the second word is a write-only strobe that tells an engine halted on a NAK to return to idle.

The bus port is single-cycle. A write takes effect at the clock edge, and read data is combinational from the address.

Top module: `i2c_csr_bank`

## Requirements
- R1: After `rst_n` is released, both control words read 0 and `irq` is 0.
- R2: A write to a control word's base offset (0x00 for the first word, 0x40 for the second) stores the whole word. A read at the base, at base+4 or at base+8 returns the stored word.
- R3: A write to base+4 sets each bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to base+8 clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R5: A one-cycle pulse on `hw_evt[i]` sets flag bit i of the second word, which is readable from the next cycle. Bit order from 7 down to 0: bus free, engine done, no acknowledge, oversize, early stop, arbitration lost, target stop, target addressed.
- R6: When a flag is cleared through the clear alias in the same cycle that `hw_evt` sets it, the flag ends up set.
- R7: `irq` is 1 exactly when some flag i (bit i) and its enable (bit i+8) of the second word are both 1.
- R8: Writing 1 to bit 31 of the first word, through the base or the set alias, clears both control words, all flags and all enables at that edge. Bit 31 then reads 0 and `irq` is 0.
- R9: Offset 0x50 reads `st_nak` at bit 28, `st_bus_busy` at bit 11 and `st_clk_busy` at bit 10, with all other bits 0. Writes to 0x50 change nothing.
- R10: Writing 1 to bit 28 of the second word, through the base or the set alias, makes `nak_release` high for exactly the next cycle. Bit 28 always reads 0.
- R11: `eng_done` clears the run bit (bit 29 of the first word) at the next edge, unless the first word is written in that same cycle. In that case the write decides the bit.
- R12: Reads of offsets that map to no register return 0. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| hw_evt | input | IRQ_N | Event pulses from the command engine |
| eng_done | input | 1 | Engine finished its command; drops the run bit |
| st_nak | input | 1 | Engine saw a NAK |
| st_bus_busy | input | 1 | Bus busy |
| st_clk_busy | input | 1 | Clock generator busy |
| cmd_word | output | 32 | First control word, to the engine |
| nak_release | output | 1 | One-cycle strobe that frees a NAK-halted engine |
| irq | output | 1 | Level interrupt |

## Verification
The alias logic is exercised with three kinds of write pattern. Plain stores show whether the base offset replaces the whole word. Sparse set and clear masks, applied over an existing non-zero value, show whether the zero bits are really left alone. Reads at every alias show whether any alias returns something other than the stored word. Each of the following is tried with and without a competing software write in the same cycle, which tells the priority rules apart from plain updates: flags raised by events, the run bit dropped by the engine, and the release strobe. Writes to the status offset and to unmapped offsets are followed by reads of both control words, so that any stray update shows at the ports.

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_PLAIN = 2'd1,
    WK_SET   = 2'd2,
    WK_CLR   = 2'd3
  } wkind_e;

  localparam int SRST_BIT       = 31;
  localparam int RUN_BIT        = 29;
  localparam int NAKREL_BIT     = 28;
  localparam int ST_NAK_BIT     = 28;
  localparam int ST_BUSBUSY_BIT = 11;
  localparam int ST_CLKBUSY_BIT = 10;

  // Next value of a word after a write of the given kind
  function automatic logic [31:0] apply_wr(input logic [31:0] cur,
                                           input logic [31:0] wd,
                                           input wkind_e      k);
    logic [31:0] r;
    case (k)
      WK_PLAIN: r = wd;
      WK_SET:   r = cur | wd;
      WK_CLR:   r = cur & ~wd;
      default:  r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2c_csr_decode.sv
module i2c_csr_decode
  import i2c_csr_pkg::*;
#(
  parameter int                 ADDR_W = 8,
  parameter logic [ADDR_W-1:0]  OFS_A  = 'h00,
  parameter logic [ADDR_W-1:0]  OFS_B  = 'h40,
  parameter logic [ADDR_W-1:0]  OFS_ST = 'h50
) (
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_a,
  output logic              hit_b,
  output logic              hit_st,
  output wkind_e            wk_a,
  output wkind_e            wk_b
);

  localparam logic [ADDR_W-1:0] STEP_SET = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_CLR = ADDR_W'(8);

  function automatic wkind_e classify(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] base);
    wkind_e k;
    if (a == base)                 k = WK_PLAIN;
    else if (a == base + STEP_SET) k = WK_SET;
    else if (a == base + STEP_CLR) k = WK_CLR;
    else                           k = WK_NONE;
    return k;
  endfunction

  wkind_e kind_a, kind_b;

  always_comb begin
    kind_a = classify(addr, OFS_A);
    kind_b = classify(addr, OFS_B);
    hit_a  = (kind_a != WK_NONE);
    hit_b  = (kind_b != WK_NONE);
    hit_st = (addr == OFS_ST);
    wk_a   = (en && we) ? kind_a : WK_NONE;
    wk_b   = (en && we) ? kind_b : WK_NONE;
  end

endmodule

// File: rtl/i2c_csr_irq.sv
module i2c_csr_irq
  import i2c_csr_pkg::*;
#(
  parameter int IRQ_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  wkind_e           wk,
  input  logic [31:0]      wdata,
  input  logic [IRQ_N-1:0] hw_evt,
  output logic [31:0]      word_q,
  output logic             irq,
  output logic             rel_pulse
);

  localparam int EN_LO = IRQ_N;
  localparam int EN_HI = 2 * IRQ_N - 1;

  logic [31:0]      raw_nxt, nxt;
  logic             rel_d;
  logic [IRQ_N-1:0] flags, ens;

  always_comb begin
    raw_nxt = apply_wr(word_q, wdata, wk);
    rel_d   = (wk != WK_NONE) && raw_nxt[NAKREL_BIT];
    nxt     = raw_nxt;
    nxt[NAKREL_BIT] = 1'b0;
    // hardware events win over a software clear
    nxt[IRQ_N-1:0]  = raw_nxt[IRQ_N-1:0] | hw_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      rel_pulse <= 1'b0;
    end else if (srst) begin
      word_q    <= '0;
      rel_pulse <= 1'b0;
    end else begin
      word_q    <= nxt;
      rel_pulse <= rel_d;
    end
  end

  assign flags = word_q[IRQ_N-1:0];
  assign ens   = word_q[EN_HI:EN_LO];
  assign irq   = |(flags & ens);

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_evt && !srst) |=> ((flags & $past(hw_evt)) == $past(hw_evt))); // R5

  AST_REL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> $past(wk != WK_NONE)); // R10

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ens)); // R7

endmodule

// File: rtl/i2c_csr_bank.sv
module i2c_csr_bank
  import i2c_csr_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_A  = 'h00,
  parameter logic [ADDR_W-1:0] OFS_B  = 'h40,
  parameter logic [ADDR_W-1:0] OFS_ST = 'h50,
  parameter int                IRQ_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [IRQ_N-1:0]  hw_evt,
  input  logic              eng_done,
  input  logic              st_nak,
  input  logic              st_bus_busy,
  input  logic              st_clk_busy,
  output logic [31:0]       cmd_word,
  output logic              nak_release,
  output logic              irq
);

  logic        hit_a, hit_b, hit_st;
  wkind_e      wk_a, wk_b;
  logic [31:0] a_q, a_raw, a_nxt, b_q, st_word;
  logic        srst_fire;

  i2c_csr_decode #(
    .ADDR_W(ADDR_W), .OFS_A(OFS_A), .OFS_B(OFS_B), .OFS_ST(OFS_ST)
  ) u_dec (
    .en(bus_en), .we(bus_we), .addr(bus_addr),
    .hit_a(hit_a), .hit_b(hit_b), .hit_st(hit_st),
    .wk_a(wk_a), .wk_b(wk_b)
  );

  always_comb begin
    a_raw     = apply_wr(a_q, bus_wdata, wk_a);
    srst_fire = (wk_a != WK_NONE) && a_raw[SRST_BIT];
    a_nxt     = a_raw;
    a_nxt[SRST_BIT] = 1'b0;
    if (eng_done && wk_a == WK_NONE) a_nxt[RUN_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         a_q <= '0;
    else if (srst_fire) a_q <= '0;
    else                a_q <= a_nxt;
  end

  i2c_csr_irq #(.IRQ_N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .srst(srst_fire),
    .wk(wk_b), .wdata(bus_wdata), .hw_evt(hw_evt),
    .word_q(b_q), .irq(irq), .rel_pulse(nak_release)
  );

  always_comb begin
    st_word = '0;
    st_word[ST_NAK_BIT]     = st_nak;
    st_word[ST_BUSBUSY_BIT] = st_bus_busy;
    st_word[ST_CLKBUSY_BIT] = st_clk_busy;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (hit_a)       bus_rdata = a_q;
      else if (hit_b)  bus_rdata = b_q;
      else if (hit_st) bus_rdata = st_word;
    end
  end

  assign cmd_word = a_q;

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fire |=> (a_q == '0 && b_q == '0 && !irq)); // R8

  AST_RUN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && wk_a == WK_NONE) |=> !a_q[RUN_BIT]); // R11

  AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !hit_a && !hit_b && hw_evt == '0 && !eng_done)
      |=> ($stable(a_q) && $stable(b_q))); // R12

endmodule

// File: tb/i2c_csr_bank_tb.sv
`timescale 1ns/1ps
module i2c_csr_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  hw_evt = '0;
  logic        eng_done = 1'b0;
  logic        st_nak = 1'b0, st_bus_busy = 1'b0, st_clk_busy = 1'b0;
  logic [31:0] cmd_word;
  logic        nak_release, irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  i2c_csr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_evt(hw_evt), .eng_done(eng_done), .st_nak(st_nak),
    .st_bus_busy(st_bus_busy), .st_clk_busy(st_clk_busy),
    .cmd_word(cmd_word), .nak_release(nak_release), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    if (bus_en && !bus_we) begin
      if (exp_q.size() == 0) check("scoreboard empty", bus_rdata, 32'hx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    hw_evt = e; @(posedge clk); #1; hw_evt = '0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    bus_read(8'h00, 32'h0, "R1 first word reset");
    bus_read(8'h40, 32'h0, "R1 second word reset");
    check("R1 irq reset", {31'd0, irq}, 32'd0);

    bus_write(8'h00, 32'h0000_1234);
    bus_read(8'h00, 32'h0000_1234, "R2 base read");
    bus_read(8'h04, 32'h0000_1234, "R2 set alias read");
    bus_read(8'h08, 32'h0000_1234, "R2 clear alias read");
    check("R2 cmd_word", cmd_word, 32'h0000_1234);

    bus_write(8'h04, 32'h00F0_0000);
    bus_read(8'h00, 32'h00F0_1234, "R3 set alias");
    bus_write(8'h08, 32'h0000_0204);
    bus_read(8'h00, 32'h00F0_1030, "R4 clear alias");

    pulse_evt(8'h80);
    bus_read(8'h40, 32'h0000_0080, "R5 bus free flag");
    pulse_evt(8'h01);
    bus_read(8'h40, 32'h0000_0081, "R5 second flag");
    check("R7 no enable no irq", {31'd0, irq}, 32'd0);

    bus_write(8'h44, 32'h0000_0100);
    check("R7 enabled flag irq", {31'd0, irq}, 32'd1);
    bus_read(8'h48, 32'h0000_0181, "R2 second word via clear alias");
    bus_write(8'h48, 32'h0000_0001);
    check("R7 cleared flag irq", {31'd0, irq}, 32'd0);
    bus_read(8'h40, 32'h0000_0180, "R4 flag clear");

    hw_evt = 8'h80;
    bus_write(8'h48, 32'h0000_0080);
    hw_evt = '0;
    bus_read(8'h40, 32'h0000_0180, "R6 event beats clear");

    bus_write(8'h44, 32'h1000_0000);
    check("R10 release pulse high", {31'd0, nak_release}, 32'd1);
    @(posedge clk); #1;
    check("R10 release pulse ends", {31'd0, nak_release}, 32'd0);
    bus_read(8'h40, 32'h0000_0180, "R10 bit 28 reads 0");

    bus_write(8'h04, 32'h2000_0000);
    bus_read(8'h00, 32'h20F0_1030, "R11 run set");
    eng_done = 1'b1; @(posedge clk); #1; eng_done = 1'b0;
    bus_read(8'h00, 32'h00F0_1030, "R11 run dropped by engine");
    eng_done = 1'b1;
    bus_write(8'h04, 32'h2000_0000);
    eng_done = 1'b0;
    bus_read(8'h00, 32'h20F0_1030, "R11 write beats done");

    st_nak = 1'b1; st_clk_busy = 1'b1;
    bus_read(8'h50, 32'h1000_0400, "R9 status bits");
    st_nak = 1'b0; st_clk_busy = 1'b0; st_bus_busy = 1'b1;
    bus_read(8'h50, 32'h0000_0800, "R9 bus busy");
    st_bus_busy = 1'b0;
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_read(8'h00, 32'h20F0_1030, "R9 status write ignored A");
    bus_read(8'h40, 32'h0000_0180, "R9 status write ignored B");

    bus_read(8'h30, 32'h0, "R12 unmapped read");
    bus_write(8'h30, 32'hFFFF_FFFF);
    bus_write(8'h4C, 32'hFFFF_FFFF);
    bus_read(8'h00, 32'h20F0_1030, "R12 unmapped write A");
    bus_read(8'h40, 32'h0000_0180, "R12 unmapped write B");

    pulse_evt(8'h01);
    check("R7 irq before soft reset", {31'd0, irq}, 32'd1);
    bus_write(8'h04, 32'h8000_0000);
    check("R8 irq after soft reset", {31'd0, irq}, 32'd0);
    bus_read(8'h00, 32'h0, "R8 first word cleared");
    bus_read(8'h40, 32'h0, "R8 second word cleared");

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule